// File: doc/BRIEF.md
# Calibrated Real-Time Clock Prescaler

This block turns a stream of oscillator enables, nominally 32768 per second, into a one-clock tick once per second. It does not trim the oscillator. Instead it changes the length of chosen seconds in whole 128-count units. The count chain has two stages. A 128-count prescaler runs freely and is never disturbed. A half-segment counter behind it closes each second, and its terminal count is the only thing that calibration moves.

A 64-minute schedule decides which seconds are corrected. The calibration code has a sign bit and a 5-bit magnitude N. The code applies to the first 2N minutes of the cycle, so minutes 62 and 63 are never touched. In each of those minutes, only the first second is altered:
- With the sign set to 1 (speed up), that second is 256 counts short.
- With the sign set to 0 (slow down), that second is 128 counts long.

The block also provides:
- a square-wave test output taken from the prescaler, which runs at 512 Hz at nominal input rate;
- the current minute index within the 64-minute cycle.

A stop input freezes every counter where it stands.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: After reset, minuteIdx is 0, secTick is low and testWave is low.
- R2: An uncorrected second lasts HalfPerSec*2^PreW counted steps (32768 by default). secTick is a single-clock pulse in the clock after the step that ends the second.
- R3: With the latched sign at 1, a corrected second lasts 256 counted steps fewer than nominal.
- R4: With the latched sign at 0, a corrected second lasts 128 counted steps more than nominal.
- R5: A second is corrected exactly when both of these hold:
  - it is second 0 of its minute;
  - minuteIdx is below twice the latched magnitude.
  A magnitude of 0 corrects nothing, and minutes 62 and 63 are never corrected.
- R6: calSign and calMag are latched only at the tick that starts a new minute. Between those ticks, changes on them have no effect. The first minute after reset runs uncorrected.
- R7: minuteIdx advances by one after SecPerMin ticks and wraps from 63 to 0. It changes only in the clock after a tick.
- R8: testWave equals bit PreW-2 of the count of steps taken since reset, which is a period of 64 steps by default. The calibration setting never affects it.
- R9: While stopReq is high, no step is taken. minuteIdx and testWave hold and no tick is issued. Counting resumes from the held state when stopReq falls.
- R10: A step is taken only in a clock where oscEn is high and stopReq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| oscEn | input | 1 | One oscillator count per clock in which it is high |
| stopReq | input | 1 | Freezes all counters while high |
| calSign | input | 1 | 1 = shorten corrected seconds, 0 = lengthen them |
| calMag | input | 5 | Calibration magnitude N; the first 2N minutes are corrected |
| secTick | output | 1 | One-clock pulse per elapsed second |
| testWave | output | 1 | Fixed prescaler tap (512 Hz at nominal rate) |
| minuteIdx | output | 6 | Minute position within the 64-minute cycle |

## Verification
The bench measures the length of every second in counted steps and compares it with a model that holds its own latched calibration. This catches the following faults:
- A swapped sign, which would give 72 steps where 48 are due (at the bench's reduced sizes).
- An off-by-one in the minute threshold, which would correct minute 2N or skip minute 2N-1.
- Sampling the calibration code mid-minute, which would change the length of a second-0 early.

The full positive setting is run over the cycle wrap. A design that corrects minutes 62 and 63, or mishandles the wrap of minuteIdx, therefore shows a wrong length there. testWave is checked against the raw step count on every clock, so a correction that touched the prescaler would break its phase. Idle and stop windows confirm that nothing advances while the step is withheld, and that counting picks up exactly where it stopped.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  // Strobes from the control side to the counting datapath.
  typedef struct packed {
    logic advance;  // take one oscillator step this clock
    logic stretch;  // current second is lengthened by one half-segment
    logic shrink;   // current second is shortened by two half-segments
  } ctl_strobe_t;
endpackage

// File: rtl/rtc_cal_datapath.sv
module rtc_cal_datapath
  import rtc_cal_pkg::*;
#(
  parameter int PreW       = 7,
  parameter int HalfPerSec = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctl_strobe_t strobe,
  output logic        secTick,
  output logic        testWave
);
  localparam int HalfW = $clog2(HalfPerSec + 2);
  localparam logic [HalfW-1:0] NomLast   = HalfW'(HalfPerSec - 1);
  localparam logic [HalfW-1:0] LongLast  = HalfW'(HalfPerSec);
  localparam logic [HalfW-1:0] ShortLast = HalfW'(HalfPerSec - 3);
  localparam logic [PreW-1:0]  PreMax    = '1;

  logic [PreW-1:0]  preCnt;
  logic [HalfW-1:0] halfCnt;
  logic [HalfW-1:0] lastHalf;
  logic             tickQ;

  always_comb begin
    if (strobe.stretch)     lastHalf = LongLast;
    else if (strobe.shrink) lastHalf = ShortLast;
    else                    lastHalf = NomLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      halfCnt <= '0;
      tickQ   <= 1'b0;
    end else begin
      tickQ <= 1'b0;
      if (strobe.advance) begin
        preCnt <= preCnt + 1'b1;
        if (preCnt == PreMax) begin
          if (halfCnt == lastHalf) begin
            halfCnt <= '0;
            tickQ   <= 1'b1;
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
      end
    end
  end

  generate
    if (PreW >= 2) begin : g_tap_hi
      assign testWave = preCnt[PreW-2];
    end else begin : g_tap_lo
      assign testWave = preCnt[0];
    end
  endgenerate

  assign secTick = tickQ;
endmodule

// File: rtl/rtc_cal_control.sv
module rtc_cal_control
  import rtc_cal_pkg::*;
#(
  parameter int SecPerMin = 60,
  parameter int MagW      = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            oscEn,
  input  logic            stopReq,
  input  logic            calSign,
  input  logic [MagW-1:0] calMag,
  input  logic            secTick,
  output ctl_strobe_t     strobe,
  output logic [MagW:0]   minuteIdx
);
  localparam int SecW = $clog2(SecPerMin);
  localparam logic [SecW-1:0] SecLast = SecW'(SecPerMin - 1);

  logic [SecW-1:0] secInMin;
  logic [MagW:0]   minQ;
  logic            calSignQ;
  logic [MagW-1:0] calMagQ;
  logic            corrSec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secInMin <= '0;
      minQ     <= '0;
      calSignQ <= 1'b0;
      calMagQ  <= '0;
    end else if (secTick) begin
      if (secInMin == SecLast) begin
        secInMin <= '0;
        minQ     <= minQ + 1'b1;
        calSignQ <= calSign;
        calMagQ  <= calMag;
      end else begin
        secInMin <= secInMin + 1'b1;
      end
    end
  end

  always_comb begin
    corrSec        = (secInMin == '0) && (minQ < {calMagQ, 1'b0});
    strobe.advance = oscEn & ~stopReq;
    strobe.stretch = corrSec & ~calSignQ;
    strobe.shrink  = corrSec & calSignQ;
  end

  assign minuteIdx = minQ;
endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
  import rtc_cal_pkg::*;
#(
  parameter int PreW       = 7,
  parameter int HalfPerSec = 256,
  parameter int SecPerMin  = 60,
  parameter int MagW       = 5
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            oscEn,
  input  logic            stopReq,
  input  logic            calSign,
  input  logic [MagW-1:0] calMag,
  output logic            secTick,
  output logic            testWave,
  output logic [MagW:0]   minuteIdx
);
  ctl_strobe_t ctlStrobe;

  rtc_cal_control #(.SecPerMin(SecPerMin), .MagW(MagW)) u_ctl (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopReq(stopReq),
    .calSign(calSign), .calMag(calMag), .secTick(secTick),
    .strobe(ctlStrobe), .minuteIdx(minuteIdx)
  );

  rtc_cal_datapath #(.PreW(PreW), .HalfPerSec(HalfPerSec)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe),
    .secTick(secTick), .testWave(testWave)
  );
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker #(
  parameter int MagW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          oscEn,
  input logic          stopReq,
  input logic          secTick,
  input logic          testWave,
  input logic [MagW:0] minuteIdx,
  input logic          adjLong,
  input logic          adjShort
);
  localparam logic [MagW:0] FirstFree = {{MagW{1'b1}}, 1'b0};

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    secTick |=> !secTick);

  p_sign_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({adjLong, adjShort}));

  p_tail_free_r5: assert property (@(posedge clk) disable iff (!rstN)
    (minuteIdx >= FirstFree) |-> !(adjLong || adjShort));

  p_min_after_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    !secTick |=> $stable(minuteIdx));

  p_stop_freeze_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!secTick && $stable(testWave)));

  p_idle_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    !oscEn |=> (!secTick && $stable(testWave)));
endmodule

bind rtc_cal_prescaler rtc_cal_checker #(.MagW(MagW)) u_chk (
  .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopReq(stopReq),
  .secTick(secTick), .testWave(testWave), .minuteIdx(minuteIdx),
  .adjLong(ctlStrobe.stretch), .adjShort(ctlStrobe.shrink)
);

// File: tb/tb_rtc_cal_prescaler.sv
`timescale 1ns/1ps
module tb_rtc_cal_prescaler;
  localparam int PreW = 3, HalfPerSec = 8, SecPerMin = 4, MagW = 5;
  localparam int HalfLen = 2 ** PreW;
  localparam int NomLen  = HalfPerSec * HalfLen;
  localparam int LongLen = NomLen + HalfLen;
  localparam int ShortLen = NomLen - 2 * HalfLen;

  logic clk = 1'b0, rstN = 1'b0, oscEn = 1'b0, stopReq = 1'b0, calSign = 1'b0;
  logic [MagW-1:0] calMag = '0;
  logic secTick, testWave;
  logic [MagW:0] minuteIdx;

  always #2 clk = ~clk;

  rtc_cal_prescaler #(.PreW(PreW), .HalfPerSec(HalfPerSec), .SecPerMin(SecPerMin), .MagW(MagW)) dut (
    .clk(clk), .rstN(rstN), .oscEn(oscEn), .stopReq(stopReq), .calSign(calSign),
    .calMag(calMag), .secTick(secTick), .testWave(testWave), .minuteIdx(minuteIdx));

  int vectors = 0, fails = 0;
  int mSec = 0, mMin = 0, mMag = 0, stepCnt = 0, totalSteps = 0;
  bit mSign = 0, prevStep = 0, tickSeen = 0;

  function automatic int expLen(int sec, int mn, bit sgn, int mag);
    if (sec == 0 && mn < 2 * mag) return sgn ? ShortLen : LongLen;
    return NomLen;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clock: observe outputs of the previous edge, then drive new inputs.
  task automatic cyc(bit en, bit stp, bit sgn, logic [MagW-1:0] mag);
    bit wrap;
    int e;
    @(negedge clk);
    wrap = 0;
    stepCnt += prevStep;
    totalSteps += prevStep;
    check(testWave == ((totalSteps >> (PreW - 2)) & 1), "R8 testWave", testWave,
          (totalSteps >> (PreW - 2)) & 1);
    if (secTick) begin
      tickSeen = 1;
      e = expLen(mSec, mMin, mSign, mMag);
      if (e == ShortLen) check(stepCnt == e, "R3 short second", stepCnt, e);
      else if (e == LongLen) check(stepCnt == e, "R4 long second", stepCnt, e);
      else check(stepCnt == e, "R2 R5 nominal second", stepCnt, e);
      check(minuteIdx == mMin, "R7 minuteIdx", minuteIdx, mMin);
      stepCnt = 0;
      if (mSec == SecPerMin - 1) begin
        mSec = 0;
        mMin = (mMin + 1) % 64;
        wrap = 1;
      end else mSec++;
    end
    oscEn = en; stopReq = stp; calSign = sgn; calMag = mag;
    prevStep = en & ~stp;
    if (wrap) begin mSign = sgn; mMag = int'(mag); end  // R6 latch point
  endtask

  initial begin
    #760000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [MagW:0] heldMin;
    bit heldWave;
    bit sg;
    logic [MagW-1:0] mg;
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(minuteIdx == 0, "R1 minuteIdx", minuteIdx, 0);
    check(secTick == 0, "R1 secTick", secTick, 0);
    check(testWave == 0, "R1 testWave", testWave, 0);

    // Full positive code across the cycle wrap (minutes 62 and 63 stay nominal).
    while (!(mMin == 2 && mSec == 1)) cyc(1, 0, 1, 5'd31);
    while (!(mMin == 3 && mSec == 0)) cyc(1, 0, 1, 5'd31);
    while (mMin != 2) cyc(1, 0, 1, 5'd31);

    // Negative codes changed mid-minute (R6): model only latches at minute start.
    for (int k = 0; k < 20; k++) begin
      mg = 5'($urandom_range(0, 31));
      repeat (NomLen * 2) cyc(1, 0, 0, mg);
      repeat (NomLen * 2) cyc(1, 0, 0, 5'($urandom_range(0, 31)));
    end

    // R10: idle window, then R9 stop window.
    heldWave = testWave; tickSeen = 0;
    repeat (3) cyc(0, 0, calSign, calMag);
    heldMin = minuteIdx; heldWave = testWave; tickSeen = 0;
    repeat (30) cyc(0, 0, calSign, calMag);
    check(!tickSeen && testWave == heldWave, "R10 idle holds", testWave, heldWave);
    repeat (3) cyc(1, 1, calSign, calMag);
    heldMin = minuteIdx; heldWave = testWave; tickSeen = 0;
    repeat (40) cyc(1, 1, calSign, calMag);
    check(!tickSeen && minuteIdx == heldMin && testWave == heldWave, "R9 stop holds",
          minuteIdx, heldMin);

    // Random enable density, stop bursts and codes.
    sg = 0; mg = 0;
    for (int k = 0; k < 60000; k++) begin
      if ($urandom_range(0, 499) == 0) begin
        sg = 1'($urandom_range(0, 1));
        mg = 5'($urandom_range(0, 31));
      end
      cyc($urandom_range(0, 9) < 7, $urandom_range(0, 19) == 0, sg, mg);
    end

    // Zero magnitude: every second nominal.
    repeat (NomLen * SecPerMin * 3) cyc(1, 0, 1, 5'd0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule